// File: doc/BRIEF.md
# Codec Input Frame Serializer

This block is the transmit half of a codec's serial link. It builds one input frame from the data waiting on the codec side and sends it out one bit at a time on `sdata_in`. That data is a register read response, 16-bit ADC samples for two phone lines, a GPIO status word and the slot-request bits. The frame starts with a 16-bit tag slot and is followed by twelve 20-bit data slots, which makes 256 bit times in all. At the nominal 12.288 MHz bit clock, one frame fits into each 48 kHz period.

The block clocks on the rising edge of the bit clock and drives each new bit from that edge, so the controller can sample it on the next falling edge. A frame begins at the first rising edge that sees `sync` high after it was low.

Read responses and line samples arrive as one-cycle strobes. Each one is held pending until the next frame start, which captures it. The frame that follows carries it exactly once. A pending line sample is marked valid only if its line is powered up and no link halt is pending. If the line is powered down or a halt is pending, the sample is dropped and its slot goes out as zeros.

Top module: `acl_in_frame`

## Requirements
- R1: Reset clears `sdata_in` to 0. Frame bit 0 (the codec-ready flag) is driven on the first rising edge that sees `sync` high after it was low, and 255 more bits follow MSB first, one per rising edge. `sdata_in` is 0 at all other times, including the bit time right after the 256th bit.
- R2: Tag slot bit 15 equals `codec_ready`. For n = 1..12, tag bit 15-n is 1 when slot n holds valid data. Tag bits 2:0 are always 0.
- R3: Slot 1 is tagged valid (tag bit 14) when a read response is pending. Its bit 19 is 0. Bits 18:12 hold the response's register index, or 0 if no response is pending. Bits 11:2 hold `slot_req` as sampled at frame start. Bits 1:0 are 0.
- R4: Slot 2 shares slot 1's validity (tag bit 13). It holds the 16-bit read data in bits 19:4 with bits 3:0 at 0, and is all zeros when invalid.
- R5: Slot 5 (tag bit 10) carries a pending line-1 sample in bits 19:4 with bits 3:0 at 0, and is all zeros when untagged.
- R6: If `l1_pdn` or `link_halt` is high at frame start, tag bit 10 and all of slot 5 are 0. Any pending line-1 sample is then discarded and does not appear in a later frame.
- R7: Slot 10 (tag bit 5) follows R5 and R6 for line 2, with `l2_pdn` in place of `l1_pdn`. The power-down flag of one line does not affect the other line.
- R8: Slot 12 is always tagged valid (tag bit 3). It carries the 20-bit `gpio_st` word sampled at frame start.
- R9: Frame start captures and clears each pending item, so every item appears in exactly one frame. A strobe that arrives after frame start waits for the next frame. A later strobe replaces an earlier item that has not yet been sent.
- R10: Slots 3, 4, 6, 7, 8, 9 and 11 and their tag bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync from the controller; a low-to-high change starts a frame |
| codec_ready | input | 1 | Codec-ready flag sent as tag bit 15 |
| rd_req | input | 1 | One-cycle strobe: a register read response is available |
| rd_idx | input | 7 | Register index echoed in slot 1 |
| rd_data | input | 16 | Register read data for slot 2 |
| slot_req | input | 10 | Slot-request bits for slot 1 bits 11:2 |
| l1_stb | input | 1 | One-cycle strobe: new line-1 ADC sample |
| l1_smp | input | 16 | Line-1 ADC sample |
| l1_pdn | input | 1 | Line-1 ADC powered down |
| l2_stb | input | 1 | One-cycle strobe: new line-2 ADC sample |
| l2_smp | input | 16 | Line-2 ADC sample |
| l2_pdn | input | 1 | Line-2 ADC powered down |
| link_halt | input | 1 | Link halt pending; suppresses both ADC slots |
| gpio_st | input | 20 | GPIO and link status word for slot 12 |
| sdata_in | output | 1 | Serial input-frame data toward the controller |

## Verification
The bench goes after power-state gating:
- A sample strobed while its line is powered down, or while a halt is pending, must not come back in the next powered-up frame. A design that only masked the tag would send the stale sample late.
- A sample strobed in the middle of a frame must appear in the frame after it. A design that latched data live would tear the current frame or lose the sample.
- A second strobe before frame start must replace the first.

For the edges of the frame:
- The bit after the 256th must be 0. An off-by-one counter would repeat or drop a bit.
- Holding `sync` high for 16 bit times must not start the frame again.
- The padding nibbles must be 0, along with slot 1's reserved bits and its index field when no response is pending. A wrong field alignment would leak data into them.

// File: rtl/acl_in_frame.sv
`timescale 1ns/1ps
module acl_in_frame #(
  parameter int TAG_W  = 16,
  parameter int NSLOT  = 12,
  parameter int SLOT_W = 20,
  parameter int SMP_W  = 16,
  parameter int IDX_W  = 7,
  parameter int REQ_W  = 10,
  parameter int GPIO_W = 20
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              codec_ready,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [SMP_W-1:0]  rd_data,
  input  logic [REQ_W-1:0]  slot_req,
  input  logic              l1_stb,
  input  logic [SMP_W-1:0]  l1_smp,
  input  logic              l1_pdn,
  input  logic              l2_stb,
  input  logic [SMP_W-1:0]  l2_smp,
  input  logic              l2_pdn,
  input  logic              link_halt,
  input  logic [GPIO_W-1:0] gpio_st,
  output logic              sdata_in
);

  localparam int FRM_W = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W = $clog2(FRM_W + 1);
  localparam int PAD_W = SLOT_W - SMP_W;
  localparam int S1 = FRM_W - TAG_W - 1 * SLOT_W;
  localparam int S2 = FRM_W - TAG_W - 2 * SLOT_W;
  localparam int S5 = FRM_W - TAG_W - 5 * SLOT_W;
  localparam int S10 = FRM_W - TAG_W - 10 * SLOT_W;
  localparam int S12 = FRM_W - TAG_W - 12 * SLOT_W;
  localparam int T1 = FRM_W - 1 - 1;
  localparam int T2 = FRM_W - 1 - 2;
  localparam int T5 = FRM_W - 1 - 5;
  localparam int T10 = FRM_W - 1 - 10;
  localparam int T12 = FRM_W - 1 - 12;

  logic             sync_q;
  logic [FRM_W-1:0] sh, frame;
  logic [CNT_W-1:0] cnt;
  logic             rd_pend, l1_pend, l2_pend;
  logic [IDX_W-1:0] idx_q;
  logic [SMP_W-1:0] dat_q, l1_q, l2_q;

  wire start = sync & ~sync_q;
  wire t_rd  = rd_pend;
  wire t_l1  = l1_pend & ~l1_pdn & ~link_halt;
  wire t_l2  = l2_pend & ~l2_pdn & ~link_halt;

  assign sdata_in = sh[FRM_W-1];

  always_comb begin
    frame = '0;
    frame[FRM_W-1] = codec_ready;
    frame[T1]  = t_rd;
    frame[T2]  = t_rd;
    frame[T5]  = t_l1;
    frame[T10] = t_l2;
    frame[T12] = 1'b1;
    frame[S1 +: SLOT_W] = {1'b0, (t_rd ? idx_q : {IDX_W{1'b0}}), slot_req, 2'b00};
    if (t_rd) frame[S2 +: SLOT_W] = {dat_q, {PAD_W{1'b0}}};
    if (t_l1) frame[S5 +: SLOT_W] = {l1_q, {PAD_W{1'b0}}};
    if (t_l2) frame[S10 +: SLOT_W] = {l2_q, {PAD_W{1'b0}}};
    frame[S12 +: SLOT_W] = gpio_st;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      sync_q <= sync;
      if (start) begin
        sh  <= frame;
        cnt <= CNT_W'(FRM_W - 1);
      end else begin
        sh  <= sh << 1;
        cnt <= (cnt != '0) ? cnt - 1'b1 : cnt;
      end
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      l1_pend <= 1'b0;
      l2_pend <= 1'b0;
      idx_q   <= '0;
      dat_q   <= '0;
      l1_q    <= '0;
      l2_q    <= '0;
    end else begin
      if (rd_req) begin
        rd_pend <= 1'b1;
        idx_q   <= rd_idx;
        dat_q   <= rd_data;
      end else if (start) rd_pend <= 1'b0;
      if (l1_stb) begin
        l1_pend <= 1'b1;
        l1_q    <= l1_smp;
      end else if (start) l1_pend <= 1'b0;
      if (l2_stb) begin
        l2_pend <= 1'b1;
        l2_q    <= l2_smp;
      end else if (start) l2_pend <= 1'b0;
    end
  end

  p_idle_low_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (cnt == '0 && !start) |=> (sdata_in == 1'b0));

  p_slot1_rsv_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    start |=> (sh[S1 + SLOT_W - 1] == 1'b0 && sh[S1 +: 2] == 2'b00));

  p_slot2_pad_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    start |=> (sh[S2 +: PAD_W] == '0));

  p_l1_gate_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (start && (l1_pdn || link_halt)) |=> (!sh[T5] && sh[S5 +: SLOT_W] == '0));

  p_l2_gate_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (start && (l2_pdn || link_halt)) |=> (!sh[T10] && sh[S10 +: SLOT_W] == '0));

  p_gpio_tag_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    start |=> sh[T12]);

  p_pend_clr_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (start && !l1_stb) |=> !l1_pend);

endmodule

// File: tb/sim_acl_in_frame.sv
`timescale 1ns/1ps
module sim_acl_in_frame;
  localparam int TCK = 82;

  logic clk = 0, rst_n = 0, sync = 0, codec_ready = 1;
  logic rd_req = 0, l1_stb = 0, l2_stb = 0;
  logic [6:0] rd_idx = '0;
  logic [15:0] rd_data = '0, l1_smp = '0, l2_smp = '0;
  logic [9:0] slot_req = '0;
  logic l1_pdn = 0, l2_pdn = 0, link_halt = 0;
  logic [19:0] gpio_st = '0;
  logic sdata_in;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [255:0] f; string tag; } exp_t;
  exp_t q[$];

  logic m_rd = 0, m_l1 = 0, m_l2 = 0;
  logic [6:0] m_idx;
  logic [15:0] m_dat, m_s1, m_s2;

  always #(TCK/2) clk = ~clk;

  acl_in_frame u0 (
    .bit_clk(clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data), .slot_req(slot_req),
    .l1_stb(l1_stb), .l1_smp(l1_smp), .l1_pdn(l1_pdn),
    .l2_stb(l2_stb), .l2_smp(l2_smp), .l2_pdn(l2_pdn),
    .link_halt(link_halt), .gpio_st(gpio_st), .sdata_in(sdata_in));

  function automatic logic [255:0] model();
    logic [15:0] tag = '0;
    logic [19:0] s [1:12];
    logic [255:0] f;
    bit v1 = m_l1 && !l1_pdn && !link_halt;
    bit v2 = m_l2 && !l2_pdn && !link_halt;
    for (int n = 1; n <= 12; n++) s[n] = '0;
    tag[15] = codec_ready;
    tag[14] = m_rd; tag[13] = m_rd;
    tag[10] = v1; tag[5] = v2; tag[3] = 1'b1;
    s[1] = {1'b0, m_rd ? m_idx : 7'd0, slot_req, 2'b00};
    if (m_rd) s[2] = {m_dat, 4'h0};
    if (v1) s[5] = {m_s1, 4'h0};
    if (v2) s[10] = {m_s2, 4'h0};
    s[12] = gpio_st;
    f = {240'd0, tag};
    for (int n = 1; n <= 12; n++) f = (f << 20) | {236'd0, s[n]};
    return f;
  endfunction

  task automatic put_rd(input logic [6:0] i, input logic [15:0] d);
    @(negedge clk); rd_req = 1; rd_idx = i; rd_data = d;
    @(negedge clk); rd_req = 0;
    m_rd = 1; m_idx = i; m_dat = d;
  endtask

  task automatic put_l1(input logic [15:0] d);
    @(negedge clk); l1_stb = 1; l1_smp = d;
    @(negedge clk); l1_stb = 0;
    m_l1 = 1; m_s1 = d;
  endtask

  task automatic put_l2(input logic [15:0] d);
    @(negedge clk); l2_stb = 1; l2_smp = d;
    @(negedge clk); l2_stb = 0;
    m_l2 = 1; m_s2 = d;
  endtask

  task automatic run_frame(input string tag, input bit mid, input logic [15:0] mid_val);
    exp_t e;
    e.f = model(); e.tag = tag;
    q.push_back(e);
    m_rd = 0; m_l1 = 0; m_l2 = 0;
    @(negedge clk); sync = 1;
    repeat (16) @(negedge clk);
    sync = 0;
    if (mid) begin
      repeat (30) @(negedge clk);
      put_l1(mid_val);
    end
    repeat (260) @(negedge clk);
  endtask

  initial begin : mon
    logic last = 0;
    logic [255:0] got;
    exp_t e;
    forever begin
      @(posedge clk);
      if (rst_n && sync && !last) begin
        for (int i = 0; i < 256; i++) begin
          @(negedge clk); got[255-i] = sdata_in;
        end
        @(negedge clk);
        n_chk++;
        if (sdata_in !== 1'b0) begin
          n_bad++;
          $display("FAIL R1 bit after frame end: actual=%b expected=0", sdata_in);
        end
        e = q.pop_front();
        n_chk++;
        if (got !== e.f) begin
          n_bad++;
          $display("FAIL %s frame: actual=%h expected=%h", e.tag, got, e.f);
        end
        last = sync;
      end else last = sync;
    end
  end

  initial begin : wdog
    #(TCK * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : drv
    slot_req = 10'h2A5; gpio_st = 20'hC3A51;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); n_chk++;
      if (sdata_in !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 reset/idle: actual=%b expected=0", sdata_in);
      end
    end
    run_frame("R2 R8 R10 empty", 0, 0);
    put_rd(7'h55, 16'hBEEF);
    run_frame("R3 R4 read response", 0, 0);
    run_frame("R9 response sent once", 0, 0);
    put_l1(16'h1234);
    run_frame("R5 line1 sample", 0, 0);
    put_l1(16'h0F0F); put_l2(16'h8001);
    run_frame("R7 both lines", 0, 0);
    l1_pdn = 1; put_l1(16'hDEAD);
    run_frame("R6 line1 power-down", 0, 0);
    l1_pdn = 0;
    run_frame("R6 suppressed sample discarded", 0, 0);
    link_halt = 1; put_l1(16'h1111); put_l2(16'h2222);
    run_frame("R6 R7 link halt", 0, 0);
    link_halt = 0; l2_pdn = 1; put_l1(16'h3333); put_l2(16'h4444);
    run_frame("R7 line2 power-down only", 0, 0);
    l2_pdn = 0;
    run_frame("R9 mid-frame strobe absent", 1, 16'hA5A5);
    run_frame("R9 mid-frame strobe next frame", 0, 0);
    put_l2(16'h5555); put_l2(16'h6666); put_rd(7'h01, 16'h0001); put_rd(7'h7F, 16'hFFFF);
    run_frame("R9 newest strobe wins", 0, 0);
    codec_ready = 0; slot_req = 10'h155; gpio_st = 20'h0ABCD;
    run_frame("R2 R8 not ready new gpio", 0, 0);
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule